// File: doc/BRIEF.md
# Hardware Cursor Pattern and Position Unit

This unit keeps the image and screen location of a two-plane hardware cursor for a display pipeline. A register port delivers byte writes that load the image, place the cursor and choose its size (32×32 or 64×64) and mode. Both bit planes sit in on-chip storage. A single auto-incrementing data register fills them: every byte of plane 0 arrives first, then every byte of plane 1.

On each clock the unit takes the current raster X/Y and returns a 2-bit cursor pixel code together with a flag that marks raster positions covered by the cursor. The stored position is biased by the cursor size, so the cursor occupies the square that ends just before the programmed coordinate. A position of (0,0) therefore keeps it off screen. Colour lookup and mixing with the video stream happen downstream.

Top module: `cursor_unit`

## Requirements
- R1: After reset, active_o and pix_code_o are 0, the position is (0,0), the mode is 00, the size is 32×32 and the RAM pointer is 0.
- R2: A write of 0x00 to register 0 returns the RAM pointer to the first byte of plane 0. A write of any other value to register 0 leaves the pointer where it was.
- R3: Each write to register 1 stores one byte and advances the pointer. The first size×size/8 bytes go to plane 0 (128 bytes at 32×32, 512 at 64×64) and the next equal count go to plane 1.
- R4: A write to register 1 at the last byte of plane 1 wraps the pointer to 0, so the next byte overwrites byte 0 of plane 0.
- R5: X position = {reg 3 bits[3:0], reg 2} and Y position = {reg 5 bits[3:0], reg 4}. The 12-bit value takes effect only on the write to the high register (3 or 5). A write to the low register alone leaves the position unchanged.
- R6: The cursor is active when raster X lies in [pos_x−size, pos_x−1] and raster Y lies in [pos_y−size, pos_y−1]. Outside that window pix_code_o is 00. Position (0,0) is never active.
- R7: Inside the window, col = x−(pos_x−size) and row = y−(pos_y−size). The byte used is row·(size/8)+col/8, and bit 7−(col mod 8) of that byte is selected. pix_code_o = {plane 1 bit, plane 0 bit}.
- R8: The mode is register 6 bits[1:0]. Mode 00 forces active_o and pix_code_o to 0. Modes 01, 10 and 11 enable output.
- R9: The size is register 7 bit 2: 0 selects 32×32 and 1 selects 64×64.
- R10: active_o and pix_code_o are registered. They reflect the raster inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register byte write strobe |
| wr_addr_i | input | 3 | Register select (0..7) |
| wr_data_i | input | 8 | Write data byte |
| raster_x_i | input | 12 | Current raster column |
| raster_y_i | input | 12 | Current raster row |
| active_o | output | 1 | Cursor covers the pixel sampled one clock earlier |
| pix_code_o | output | 2 | Cursor pixel code {plane 1, plane 0} |

## Verification
The hardest state to reach from the ports is the pointer wrap. A whole image must first be streamed through the data register, and extra bytes must then overwrite the start of plane 0. The only way to see the effect is through the pixel output of the top cursor row. The bench streams complete random images in both sizes, then adds three extra bytes and probes the first 24 columns of row 0. It also inserts a non-zero pointer write partway through a load. Random probes are packed around the window edges, so the off-by-one limits of the size-biased window are hit repeatedly in both sizes.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned SIZE_BIT = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_PTR  = 3'd0,
    SEL_RAM  = 3'd1,
    SEL_XLO  = 3'd2,
    SEL_XHI  = 3'd3,
    SEL_YLO  = 3'd4,
    SEL_YHI  = 3'd5,
    SEL_MODE = 3'd6,
    SEL_SIZE = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_A   = 2'd1,
    MODE_B   = 2'd2,
    MODE_C   = 2'd3
  } cur_mode_e;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
#(
  parameter int unsigned POS_W   = 12,
  parameter int unsigned MIN_DIM = 32,
  parameter int unsigned MAX_DIM = 64,
  parameter int unsigned PTR_W   = 10,
  parameter int unsigned IDX_W   = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [POS_W-1:0]  pos_x_o,
  output logic [POS_W-1:0]  pos_y_o,
  output cur_mode_e         mode_o,
  output logic              big_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              ram_we_o,
  output logic              ram_plane_o,
  output logic [IDX_W-1:0]  ram_idx_o,
  output logic [DATA_W-1:0] ram_data_o
);
  localparam int unsigned HI_W      = POS_W - DATA_W;
  localparam int unsigned MIN_BYTES = MIN_DIM * MIN_DIM / 8;
  localparam int unsigned MAX_BYTES = MAX_DIM * MAX_DIM / 8;

  reg_sel_e          sel;
  logic [DATA_W-1:0] x_lo_q, y_lo_q;
  logic [POS_W-1:0]  pos_x_q, pos_y_q;
  cur_mode_e         mode_q;
  logic              big_q;
  logic [PTR_W-1:0]  ptr_q, plane_bytes, offs, last;
  logic              in_p1;

  always_comb begin
    sel         = reg_sel_e'(wr_addr_i);
    plane_bytes = big_q ? PTR_W'(MAX_BYTES) : PTR_W'(MIN_BYTES);
    last        = (plane_bytes << 1) - PTR_W'(1);
    in_p1       = ptr_q >= plane_bytes;
    offs        = in_p1 ? ptr_q - plane_bytes : ptr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_lo_q  <= '0;
      y_lo_q  <= '0;
      pos_x_q <= '0;
      pos_y_q <= '0;
      mode_q  <= MODE_OFF;
      big_q   <= 1'b0;
      ptr_q   <= '0;
    end else if (wr_en_i) begin
      unique case (sel)
        SEL_PTR:  if (wr_data_i == '0) ptr_q <= '0;
        SEL_RAM:  ptr_q <= (ptr_q >= last) ? '0 : ptr_q + PTR_W'(1);
        SEL_XLO:  x_lo_q <= wr_data_i;
        SEL_XHI:  pos_x_q <= {wr_data_i[HI_W-1:0], x_lo_q};
        SEL_YLO:  y_lo_q <= wr_data_i;
        SEL_YHI:  pos_y_q <= {wr_data_i[HI_W-1:0], y_lo_q};
        SEL_MODE: mode_q <= cur_mode_e'(wr_data_i[1:0]);
        SEL_SIZE: big_q <= wr_data_i[SIZE_BIT];
        default:  ;
      endcase
    end
  end

  assign pos_x_o     = pos_x_q;
  assign pos_y_o     = pos_y_q;
  assign mode_o      = mode_q;
  assign big_o       = big_q;
  assign ptr_o       = ptr_q;
  assign ram_we_o    = wr_en_i && (sel == SEL_RAM);
  assign ram_plane_o = in_p1;
  assign ram_idx_o   = offs[IDX_W-1:0];
  assign ram_data_o  = wr_data_i;
endmodule

// File: rtl/cursor_ram.sv
module cursor_ram
  import cursor_pkg::*;
#(
  parameter int unsigned IDX_W = 9,
  parameter int unsigned DEPTH = 512
) (
  input  logic                   clk_i,
  input  logic                   we_i,
  input  logic                   plane_i,
  input  logic [IDX_W-1:0]       widx_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [IDX_W-1:0]       ridx_i,
  output logic [1:0][DATA_W-1:0] rdata_o
);
  for (genvar g = 0; g < 2; g++) begin : g_plane
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && (plane_i == 1'(g))) mem[widx_i] <= wdata_i;
    end
    assign rdata_o[g] = mem[ridx_i];
  end
endmodule

// File: rtl/cursor_window.sv
module cursor_window
  import cursor_pkg::*;
#(
  parameter int unsigned POS_W   = 12,
  parameter int unsigned MIN_DIM = 32,
  parameter int unsigned MAX_DIM = 64,
  parameter int unsigned IDX_W   = 9
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [POS_W-1:0]       rx_i,
  input  logic [POS_W-1:0]       ry_i,
  input  logic [POS_W-1:0]       pos_x_i,
  input  logic [POS_W-1:0]       pos_y_i,
  input  cur_mode_e              mode_i,
  input  logic                   big_i,
  output logic [IDX_W-1:0]       ridx_o,
  input  logic [1:0][DATA_W-1:0] rdata_i,
  output logic                   active_o,
  output logic [1:0]             code_o
);
  localparam int unsigned CW     = $clog2(MAX_DIM);
  localparam int unsigned MAX_SH = $clog2(MAX_DIM) - 3;
  localparam int unsigned MIN_SH = $clog2(MIN_DIM) - 3;
  localparam int unsigned SW     = $clog2(MAX_SH + 1);

  logic [POS_W:0] dim, sum_x, sum_y, rx_e, ry_e, px_e, py_e;
  logic [CW-1:0]  col, row;
  logic [SW-1:0]  row_sh;
  logic [2:0]     bit_sel;
  logic           hit, show;
  logic           active_q;
  logic [1:0]     code_q;

  always_comb begin
    dim     = big_i ? (POS_W+1)'(MAX_DIM) : (POS_W+1)'(MIN_DIM);
    rx_e    = {1'b0, rx_i};
    ry_e    = {1'b0, ry_i};
    px_e    = {1'b0, pos_x_i};
    py_e    = {1'b0, pos_y_i};
    sum_x   = rx_e + dim;
    sum_y   = ry_e + dim;
    hit     = (rx_e < px_e) && (sum_x >= px_e) && (ry_e < py_e) && (sum_y >= py_e);
    show    = hit && (mode_i != MODE_OFF);
    col     = CW'(sum_x - px_e);
    row     = CW'(sum_y - py_e);
    row_sh  = big_i ? SW'(MAX_SH) : SW'(MIN_SH);
    ridx_o  = (IDX_W'(row) << row_sh) | IDX_W'(col >> 3);
    bit_sel = ~col[2:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      code_q   <= 2'b00;
    end else begin
      active_q <= show;
      code_q   <= show ? {rdata_i[1][bit_sel], rdata_i[0][bit_sel]} : 2'b00;
    end
  end

  assign active_o = active_q;
  assign code_o   = code_q;
endmodule

// File: rtl/cursor_unit.sv
module cursor_unit
  import cursor_pkg::*;
#(
  parameter int unsigned POS_W   = 12,
  parameter int unsigned MIN_DIM = 32,
  parameter int unsigned MAX_DIM = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [POS_W-1:0]  raster_x_i,
  input  logic [POS_W-1:0]  raster_y_i,
  output logic              active_o,
  output logic [1:0]        pix_code_o
);
  localparam int unsigned DEPTH = MAX_DIM * MAX_DIM / 8;
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned PTR_W = IDX_W + 1;

  logic [POS_W-1:0]       pos_x, pos_y;
  cur_mode_e              mode;
  logic                   big;
  logic [PTR_W-1:0]       ptr;
  logic                   ram_we, ram_plane;
  logic [IDX_W-1:0]       ram_widx, ram_ridx;
  logic [DATA_W-1:0]      ram_wdata;
  logic [1:0][DATA_W-1:0] ram_rdata;

  cursor_regs #(
    .POS_W(POS_W), .MIN_DIM(MIN_DIM), .MAX_DIM(MAX_DIM), .PTR_W(PTR_W), .IDX_W(IDX_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .pos_x_o(pos_x), .pos_y_o(pos_y), .mode_o(mode),
    .big_o(big), .ptr_o(ptr), .ram_we_o(ram_we), .ram_plane_o(ram_plane),
    .ram_idx_o(ram_widx), .ram_data_o(ram_wdata)
  );

  cursor_ram #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_ram (
    .clk_i(clk_i), .we_i(ram_we), .plane_i(ram_plane), .widx_i(ram_widx),
    .wdata_i(ram_wdata), .ridx_i(ram_ridx), .rdata_o(ram_rdata)
  );

  cursor_window #(
    .POS_W(POS_W), .MIN_DIM(MIN_DIM), .MAX_DIM(MAX_DIM), .IDX_W(IDX_W)
  ) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(raster_x_i), .ry_i(raster_y_i),
    .pos_x_i(pos_x), .pos_y_i(pos_y), .mode_i(mode), .big_i(big),
    .ridx_o(ram_ridx), .rdata_i(ram_rdata), .active_o(active_o), .code_o(pix_code_o)
  );
endmodule

// File: rtl/cursor_unit_chk.sv
module cursor_unit_chk
  import cursor_pkg::*;
#(
  parameter int unsigned POS_W   = 12,
  parameter int unsigned MIN_DIM = 32,
  parameter int unsigned MAX_DIM = 64,
  parameter int unsigned PTR_W   = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [SEL_W-1:0]  wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [POS_W-1:0]  raster_x_i,
  input logic [POS_W-1:0]  raster_y_i,
  input logic              active_o,
  input logic [1:0]        pix_code_o,
  input logic [POS_W-1:0]  pos_x,
  input logic [POS_W-1:0]  pos_y,
  input cur_mode_e         mode,
  input logic              big,
  input logic [PTR_W-1:0]  ptr
);
  localparam logic [PTR_W-1:0] LAST_BIG   = PTR_W'(2 * MAX_DIM * MAX_DIM / 8 - 1);
  localparam logic [PTR_W-1:0] LAST_SMALL = PTR_W'(2 * MIN_DIM * MIN_DIM / 8 - 1);

  // R2
  ptr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == SEL_PTR && wr_data_i == '0) |=> (ptr == '0));

  // R4
  ptr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == SEL_RAM && ptr == (big ? LAST_BIG : LAST_SMALL)) |=> (ptr == '0));

  // R5
  lo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i == SEL_XLO || wr_addr_i == SEL_YLO)) |=> ($stable(pos_x) && $stable(pos_y)));

  // R6
  window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> ($past(raster_x_i) < $past(pos_x) && $past(raster_y_i) < $past(pos_y)));

  // R6
  idle_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> (pix_code_o == 2'b00));

  // R8
  mode_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_OFF) |=> !active_o);
endmodule

bind cursor_unit cursor_unit_chk #(
  .POS_W(POS_W), .MIN_DIM(MIN_DIM), .MAX_DIM(MAX_DIM), .PTR_W(PTR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .raster_x_i(raster_x_i), .raster_y_i(raster_y_i),
  .active_o(active_o), .pix_code_o(pix_code_o), .pos_x(pos_x), .pos_y(pos_y),
  .mode(mode), .big(big), .ptr(ptr)
);

// File: tb/cursor_unit_test.sv
module cursor_unit_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [11:0] rx = '0, ry = '0;
  logic        active;
  logic [1:0]  code;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] ref_p0 [512];
  logic [7:0] ref_p1 [512];
  int ref_ptr = 0, ref_px = 0, ref_py = 0, ref_mode = 0;
  bit ref_big = 0;
  logic [7:0] ref_xlo = 0, ref_ylo = 0;

  always #(CLK_P/2) clk = ~clk;

  cursor_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .raster_x_i(rx), .raster_y_i(ry),
    .active_o(active), .pix_code_o(code)
  );

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual {act,code}=%b expected %b (x=%0d y=%0d)", req, act, exp, rx, ry);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    int pb;
    pb = ref_big ? 512 : 128;
    case (a)
      3'd0: if (d == 0) ref_ptr = 0;
      3'd1: begin
        if (ref_ptr < pb) ref_p0[ref_ptr] = d; else ref_p1[ref_ptr-pb] = d;
        ref_ptr = (ref_ptr >= 2*pb-1) ? 0 : ref_ptr + 1;
      end
      3'd2: ref_xlo = d;
      3'd3: ref_px = {d[3:0], ref_xlo};
      3'd4: ref_ylo = d;
      3'd5: ref_py = {d[3:0], ref_ylo};
      3'd6: ref_mode = d[1:0];
      3'd7: ref_big = d[2];
    endcase
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_pos(int x, int y);
    wr(3'd2, x[7:0]); wr(3'd3, 8'(x >> 8));
    wr(3'd4, y[7:0]); wr(3'd5, 8'(y >> 8));
  endtask

  task automatic load_image(int nonzero_at);
    int pb;
    pb = ref_big ? 512 : 128;
    wr(3'd0, 8'h00);
    for (int i = 0; i < 2*pb; i++) begin
      if (i == nonzero_at) wr(3'd0, 8'h07);
      wr(3'd1, 8'($urandom));
    end
  endtask

  function automatic logic [2:0] exp_pix(int x, int y);
    int sz, col, row, idx, b;
    if (ref_mode == 0) return 3'b000;
    sz = ref_big ? 64 : 32;
    if (x < ref_px && x + sz >= ref_px && y < ref_py && y + sz >= ref_py) begin
      col = x + sz - ref_px; row = y + sz - ref_py;
      idx = row * (sz/8) + col/8; b = 7 - col % 8;
      return {1'b1, ref_p1[idx][b], ref_p0[idx][b]};
    end
    return 3'b000;
  endfunction

  task automatic probe(int x, int y, string req);
    rx = 12'(x); ry = 12'(y);
    @(negedge clk);
    check(req, {active, code}, exp_pix(int'(rx), int'(ry)));
  endtask

  task automatic edges(string req);
    int sz;
    sz = ref_big ? 64 : 32;
    probe(ref_px - sz,     ref_py - sz,     req);
    probe(ref_px - sz - 1, ref_py - sz,     req);
    probe(ref_px - 1,      ref_py - 1,      req);
    probe(ref_px,          ref_py - 1,      req);
    probe(ref_px - 1,      ref_py,          req);
    probe(ref_px - sz,     ref_py - sz - 1, req);
  endtask

  task automatic rand_probes(int n, string req);
    int sz;
    sz = ref_big ? 64 : 32;
    for (int i = 0; i < n; i++)
      probe((ref_px - sz - 3 + int'($urandom_range(sz + 5))) & 12'hFFF,
            (ref_py - sz - 3 + int'($urandom_range(sz + 5))) & 12'hFFF, req);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 512; i++) begin ref_p0[i] = '0; ref_p1[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {active, code}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    probe(0, 0, "R1");
    wr(3'd6, 8'h01);
    // R1 position (0,0) after reset stays hidden
    probe(0, 0, "R1");
    probe(4095, 4095, "R1");

    // R3 R7 R9 32x32 image
    wr(3'd7, 8'h00);
    load_image(-1);
    set_pos(100, 50);
    edges("R6");
    rand_probes(300, "R7");

    // R10 registered output
    probe(0, 0, "R10");
    rx = 12'(ref_px - 1); ry = 12'(ref_py - 1);
    #1 check("R10", {active, code}, 3'b000);
    @(negedge clk);
    check("R10", {active, code}, exp_pix(ref_px - 1, ref_py - 1));

    // R5 low write only leaves position
    wr(3'd2, 8'h55);
    wr(3'd4, 8'h66);
    edges("R5");
    wr(3'd3, 8'h00);
    wr(3'd5, 8'h00);
    edges("R5");
    set_pos(100, 50);

    // R6 position (0,0) hides
    set_pos(0, 0);
    for (int i = 0; i < 4; i++) probe(i, i, "R6");
    probe(4095, 4095, "R6");
    probe(4064, 4064, "R6");

    // R9 R3 64x64 image, R2 non-zero pointer write mid-load
    wr(3'd7, 8'h04);
    wr(3'd6, 8'h03);
    load_image(300);
    set_pos(2000 + int'($urandom_range(1000)), 100 + int'($urandom_range(3000)));
    edges("R9");
    rand_probes(400, "R2");

    // R4 wrap: extra bytes overwrite plane 0 start
    wr(3'd1, 8'hA5); wr(3'd1, 8'h3C); wr(3'd1, 8'hF0);
    for (int c = 0; c < 24; c++) probe(ref_px - 64 + c, ref_py - 64, "R4");

    // R8 mode 00 disables
    wr(3'd6, 8'h00);
    edges("R8");
    rand_probes(40, "R8");
    wr(3'd6, 8'h02);
    edges("R8");

    // R3 R4 back to 32x32, reload and wrap
    wr(3'd7, 8'h00);
    set_pos(31 + int'($urandom_range(4000)), 31 + int'($urandom_range(4000)));
    load_image(-1);
    wr(3'd1, 8'h81);
    for (int c = 0; c < 16; c++) probe(ref_px - 32 + c, ref_py - 32, "R4");
    rand_probes(300, "R3");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule